// File: doc/BRIEF.md
# Configurable GPIO Port Controller

The block is an eight-pin general purpose I/O port that software controls over a simple synchronous register bus. It holds an output-value register and a drive-enable register. Each of these two registers can be changed in place through set, clear and toggle alias addresses, so no read-modify-write is needed. Every pin has its own configuration byte. That byte holds a polarity-invert bit, which applies to the input path and to the output path, and a two-bit input sense mode. It also holds five spare bits that are stored and read back but drive nothing.

Pad inputs are synchronized and then inverted where a pin asks for it. The result can be read back, and it feeds a detector on each pin. A detector raises a sticky per-pin flag, and two interrupt lines each combine those flags through their own pin mask. A multi-pin select register lets one configuration write reach several pins at once. A routing register can replace the output value of one fixed pin with a sampled clock tap, and of the top pin with an event signal.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output, drive-enable, flag, interrupt-mask, multi-pin select, routing and per-pin configuration registers all read 0. `pad_oe` is 0, and `irq0` and `irq1` are low.
- R2: Addresses 1/2/3 set, clear or toggle the output register bits written as 1, and addresses 5/6/7 do the same for the drive-enable register. Bits written as 0 are unchanged. A write to address 0 or 4 loads the register directly.
- R3: `pad_oe[i]` follows drive-enable bit i, and `pad_out[i]` equals output bit i XOR the pin's invert bit (configuration bit 2). Both appear two cycles after the write.
- R4: A read of address 8 returns the two-flop synchronized pad value XOR each pin's invert bit.
- R5: The sense mode in configuration bits [1:0] acts on the inverted input. 0 flags any edge, 1 flags a rising edge, 2 flags a falling edge and 3 flags a low level. A flag, once set, stays set.
- R6: In low-level mode the flag is set again every cycle while the inverted input stays low, so a clear has no lasting effect during that time.
- R7: Writing to the flag register (address 9) clears the flags written as 1. Flags written as 0 are unchanged. A new sense hit in the same cycle wins over the clear.
- R8: `irq0` is high when any flag ANDed with mask 0 (address 10) is set. `irq1` does the same with mask 1 (address 11). Each line is registered one cycle behind its inputs.
- R9: When the multi-pin select register (address 12) is nonzero, a write to any configuration address (16 + pin) stores the data in every selected pin and clears the select register. When it is zero, only the addressed pin is written.
- R10: Routing bit 0 (address 13) makes pin `CLK_PIN` output the sampled `clk_tap`. Routing bit 1 makes the top pin output `evt_in`. Both routed values are still XORed with that pin's invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels (registered) |
| pad_oe | output | 8 | Pad drive enables (registered) |
| clk_tap | input | 1 | Clock signal sampled for routing to a pin |
| evt_in | input | 1 | Event signal for routing to the top pin |
| irq0 | output | 1 | Port interrupt line 0 |
| irq1 | output | 1 | Port interrupt line 1 |

## Verification
If the output or drive-enable register holds a wrong value after an alias write, it shows on `pad_out` or `pad_oe` two cycles later. A bad invert bit shows up both on those pads and on the input readback. If the sense logic or the flags go wrong, the flag register reads back a wrong value a few cycles after a pad change. That error reaches `irq0` or `irq1` one cycle after a mask is written. A stale multi-pin select shows up in the next configuration write, which then reaches the wrong pins, and a readback of that pin's configuration exposes it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SENSE_ANY  = 2'd0,
    SENSE_RISE = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  localparam int A_OUT      = 0;
  localparam int A_OUT_SET  = 1;
  localparam int A_OUT_CLR  = 2;
  localparam int A_OUT_TGL  = 3;
  localparam int A_DIR      = 4;
  localparam int A_DIR_SET  = 5;
  localparam int A_DIR_CLR  = 6;
  localparam int A_DIR_TGL  = 7;
  localparam int A_IN       = 8;
  localparam int A_FLAGS    = 9;
  localparam int A_MASK0    = 10;
  localparam int A_MASK1    = 11;
  localparam int A_MULTI    = 12;
  localparam int A_ROUTE    = 13;
  localparam int A_CFG_BASE = 16;

  localparam int CFG_INV_BIT = 2;
endpackage

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_port_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pad,
  input  logic   invert,
  input  sense_e mode,
  output logic   level,
  output logic   hit
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pad;
      sync2_q <= sync1_q;
      prev_q  <= level;
    end
  end

  assign level = sync2_q ^ invert;

  always_comb begin
    unique case (mode)
      SENSE_ANY:  hit = level ^ prev_q;
      SENSE_RISE: hit = level & ~prev_q;
      SENSE_FALL: hit = ~level & prev_q;
      default:    hit = ~level;
    endcase
  end
endmodule

// File: rtl/gpio_flag_irq.sv
module gpio_flag_irq #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] hit,
  input  logic            clr_we,
  input  logic [PINS-1:0] clr_mask,
  input  logic [PINS-1:0] mask0,
  input  logic [PINS-1:0] mask1,
  output logic [PINS-1:0] flags,
  output logic            irq0,
  output logic            irq1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq0  <= 1'b0;
      irq1  <= 1'b0;
    end else begin
      flags <= (clr_we ? (flags & ~clr_mask) : flags) | hit;
      irq0  <= |(flags & mask0);
      irq1  <= |(flags & mask1);
    end
  end

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~$past(flags) & ~$past(hit)) == '0));

  // R8
  irq_line_chk: assert property (@(posedge clk) disable iff (rst)
    (irq0 == $past(|(flags & mask0))) && (irq1 == $past(|(flags & mask1))));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8,
  parameter int CLK_PIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic              clk_tap,
  input  logic              evt_in,
  output logic              irq0,
  output logic              irq1
);
  localparam int IDX_W   = (PINS > 1) ? $clog2(PINS) : 1;
  localparam int EVT_PIN = PINS - 1;

  logic [PINS-1:0]   out_q, dir_q, mask0_q, mask1_q, multi_q;
  logic [1:0]        route_q;
  logic [DATA_W-1:0] cfg_q [PINS];
  logic [PINS-1:0]   level, hit, flags, inv;
  logic [PINS-1:0]   wd;
  logic              cfg_hit;
  logic [IDX_W-1:0]  cfg_idx;
  int                addr_i;

  assign wd      = bus_wdata[PINS-1:0];
  assign addr_i  = int'(bus_addr);
  assign cfg_hit = (addr_i >= A_CFG_BASE) && (addr_i < A_CFG_BASE + PINS);
  assign cfg_idx = IDX_W'(addr_i - A_CFG_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask0_q <= '0;
      mask1_q <= '0;
      multi_q <= '0;
      route_q <= '0;
      for (int i = 0; i < PINS; i++) cfg_q[i] <= '0;
    end else if (bus_we) begin
      case (addr_i)
        A_OUT:     out_q   <= wd;
        A_OUT_SET: out_q   <= out_q | wd;
        A_OUT_CLR: out_q   <= out_q & ~wd;
        A_OUT_TGL: out_q   <= out_q ^ wd;
        A_DIR:     dir_q   <= wd;
        A_DIR_SET: dir_q   <= dir_q | wd;
        A_DIR_CLR: dir_q   <= dir_q & ~wd;
        A_DIR_TGL: dir_q   <= dir_q ^ wd;
        A_MASK0:   mask0_q <= wd;
        A_MASK1:   mask1_q <= wd;
        A_MULTI:   multi_q <= wd;
        A_ROUTE:   route_q <= bus_wdata[1:0];
        default: begin
          if (cfg_hit) begin
            if (multi_q != '0) begin
              for (int i = 0; i < PINS; i++)
                if (multi_q[i]) cfg_q[i] <= bus_wdata;
            end else begin
              cfg_q[cfg_idx] <= bus_wdata;
            end
            multi_q <= '0;
          end
        end
      endcase
    end
  end

  // Per-pin input path and output driver.
  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic drv;
    assign inv[g] = cfg_q[g][CFG_INV_BIT];

    gpio_pin_sense u_sense (
      .clk    (clk),
      .rst    (rst),
      .pad    (pad_in[g]),
      .invert (inv[g]),
      .mode   (sense_e'(cfg_q[g][1:0])),
      .level  (level[g]),
      .hit    (hit[g])
    );

    always_comb begin
      drv = out_q[g];
      if (g == CLK_PIN && route_q[0]) drv = clk_tap;
      if (g == EVT_PIN && route_q[1]) drv = evt_in;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[g] <= 1'b0;
        pad_oe[g]  <= 1'b0;
      end else begin
        pad_out[g] <= drv ^ inv[g];
        pad_oe[g]  <= dir_q[g];
      end
    end
  end

  gpio_flag_irq #(.PINS(PINS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr_we   (bus_we && addr_i == A_FLAGS),
    .clr_mask (wd),
    .mask0    (mask0_q),
    .mask1    (mask1_q),
    .flags    (flags),
    .irq0     (irq0),
    .irq1     (irq1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (addr_i)
        A_OUT, A_OUT_SET, A_OUT_CLR, A_OUT_TGL: bus_rdata[PINS-1:0] <= out_q;
        A_DIR, A_DIR_SET, A_DIR_CLR, A_DIR_TGL: bus_rdata[PINS-1:0] <= dir_q;
        A_IN:    bus_rdata[PINS-1:0] <= level;
        A_FLAGS: bus_rdata[PINS-1:0] <= flags;
        A_MASK0: bus_rdata[PINS-1:0] <= mask0_q;
        A_MASK1: bus_rdata[PINS-1:0] <= mask1_q;
        A_MULTI: bus_rdata[PINS-1:0] <= multi_q;
        A_ROUTE: bus_rdata[1:0]      <= route_q;
        default: if (cfg_hit) bus_rdata <= cfg_q[cfg_idx];
      endcase
    end
  end

  // R3
  drive_enable_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe == $past(dir_q));

  // R9
  multi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && cfg_hit && multi_q != '0) |=> (multi_q == '0));
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  localparam int CLK_PIN = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pad_in = '0, pad_out, pad_oe;
  logic clk_tap = 1'b0, evt_in = 1'b0, irq0, irq1;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.CLK_PIN(CLK_PIN)) u_gpio_port (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .clk_tap(clk_tap), .evt_in(evt_in),
    .irq0(irq0), .irq1(irq1)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] sense_hits(logic [7:0] o, logic [7:0] n, logic [15:0] modes);
    logic [7:0] h = '0;
    for (int i = 0; i < 8; i++) begin
      case (modes[2*i +: 2])
        2'd0: h[i] = o[i] ^ n[i];
        2'd1: h[i] = ~o[i] & n[i];
        2'd2: h[i] = o[i] & ~n[i];
        default: h[i] = ~n[i];
      endcase
    end
    return h;
  endfunction

  function automatic logic [7:0] low_pins(logic [7:0] n, logic [15:0] modes);
    logic [7:0] h = '0;
    for (int i = 0; i < 8; i++) h[i] = (modes[2*i +: 2] == 2'd3) && !n[i];
    return h;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, m_out, m_dir, inv, d, cur, nv, expf, m0, m1, c;
    logic [15:0] modes;
    int op;
    void'($urandom(32'd1234));
    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 irq", {6'b0, irq1, irq0}, 8'h00);
    rd(0, r);  chk("R1 out", r, 8'h00);
    rd(4, r);  chk("R1 dir", r, 8'h00);
    rd(9, r);  chk("R1 flags", r, 8'h00);
    rd(12, r); chk("R1 multi", r, 8'h00);
    rd(13, r); chk("R1 route", r, 8'h00);
    rd(18, r); chk("R1 cfg", r, 8'h00);

    // R2 / R3 alias writes
    m_out = '0; m_dir = '0;
    wr(1, 8'hFF); wr(2, 8'h00); m_out = 8'hFF;
    wr(7, 8'h00); wr(5, 8'h00);
    for (int k = 0; k < 40; k++) begin
      op = $urandom % 8;
      d  = 8'($urandom);
      wr(op, d);
      case (op)
        0: m_out = d;
        1: m_out = m_out | d;
        2: m_out = m_out & ~d;
        3: m_out = m_out ^ d;
        4: m_dir = d;
        5: m_dir = m_dir | d;
        6: m_dir = m_dir & ~d;
        default: m_dir = m_dir ^ d;
      endcase
      idle(1);
      chk("R3 pad_out", pad_out, m_out);
      chk("R3 pad_oe", pad_oe, m_dir);
      rd(op, r);
      chk("R2 alias readback", r, (op < 4) ? m_out : m_dir);
    end

    // R9 multi-pin configuration write
    inv = 8'hA6;
    wr(12, inv);
    wr(16, 8'h04);
    rd(12, r); chk("R9 multi cleared", r, 8'h00);
    for (int i = 0; i < 8; i++) begin
      rd(16 + i, r); chk("R9 cfg pin", r, inv[i] ? 8'h04 : 8'h00);
    end
    wr(17, 8'hF8 | 8'(inv[1]) << 2);
    rd(17, r); chk("R9 single pin cfg", r, 8'hF8 | 8'(inv[1]) << 2);
    rd(16, r); chk("R9 neighbour untouched", r, inv[0] ? 8'h04 : 8'h00);
    wr(17, 8'(inv[1]) << 2);
    idle(1);
    chk("R3 inverted pad_out", pad_out, m_out ^ inv);

    // R4 input readback
    for (int k = 0; k < 10; k++) begin
      pad_in = 8'($urandom);
      idle(3);
      rd(8, r); chk("R4 input", r, pad_in ^ inv);
    end

    // R5 / R6 / R7 / R8 sensing and interrupts
    modes = '0;
    for (int i = 0; i < 8; i++) begin
      modes[2*i +: 2] = 2'($urandom);
      if (i == 0) modes[1:0] = 2'd3;
      if (i == 1) modes[3:2] = 2'd1;
      if (i == 2) modes[5:4] = 2'd2;
      if (i == 3) modes[7:6] = 2'd0;
      wr(16 + i, {5'b0, inv[i], modes[2*i +: 2]});
    end
    cur = 8'($urandom);
    pad_in = cur;
    idle(6);
    wr(9, 8'hFF);
    idle(3);
    expf = low_pins(cur ^ inv, modes);
    rd(9, r); chk("R6 flags after clear", r, expf);
    for (int k = 0; k < 30; k++) begin
      nv = 8'($urandom);
      pad_in = nv;
      idle(6);
      expf = expf | sense_hits(cur ^ inv, nv ^ inv, modes);
      cur = nv;
      rd(9, r); chk("R5 sense flags", r, expf);
      m0 = 8'($urandom); m1 = 8'($urandom);
      wr(10, m0); wr(11, m1);
      idle(1);
      chk("R8 irq lines", {6'b0, irq1, irq0}, {6'b0, |(expf & m1), |(expf & m0)});
      wr(9, 8'h00);
      rd(9, r); chk("R7 zero write", r, expf);
      c = 8'($urandom);
      wr(9, c);
      idle(2);
      expf = (expf & ~c) | low_pins(cur ^ inv, modes);
      rd(9, r); chk("R7 partial clear", r, expf);
    end

    // R10 routing
    wr(4, 8'hFF); wr(0, 8'h00);
    wr(13, 8'h01);
    clk_tap = 1'b1; idle(3);
    chk("R10 clock tap high", pad_out, inv ^ (8'h01 << CLK_PIN));
    clk_tap = 1'b0; idle(3);
    chk("R10 clock tap low", pad_out, inv);
    wr(13, 8'h02);
    evt_in = 1'b1; idle(3);
    chk("R10 event high", pad_out, inv ^ 8'h80);
    wr(13, 8'h00); idle(2);
    chk("R10 route off", pad_out, inv);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule